// File: doc/BRIEF.md
# Timer Slave-Mode Controller

This block sits between a timer's input conditioning and its counter register. It decides, cycle by cycle, whether the counter advances and in which direction, and whether the counter is cleared, an update event is raised, or the counter's run bit is set. A three-bit mode field selects one of eight behaviours. Mode 0 counts freely on the internal tick. Modes 1 to 3 decode a two-phase quadrature encoder. Modes 4 to 7 follow a trigger input taken from a bank of trigger sources: reset on a rising edge, gating while the trigger is high, starting on a rising edge, or clocking on each rising edge.

All edges are found synchronously. Each input is compared with a registered copy of itself, so each edge gives exactly one strobe. All outputs are registered. An output reflects the inputs sampled at the clock edge that loads it and holds for one cycle. The counter register, the input filters and polarity control belong to neighbouring blocks.

Top module: `tmr_slave_ctl`

## Requirements
- R1: While reset is asserted, `cnt_step`, `cnt_clear`, `upd_req` and `run_set` are 0 and `cnt_up` is 1.
- R2: Mode 0 (free run): `cnt_step` equals `tick_en` as sampled at the previous clock edge, and `cnt_up` is 1.
- R3: The trigger signal used by modes 4 to 7 is `trig_src[trig_sel]`. The other trigger sources have no effect.
- R4: Mode 1: a change of `ti2` gives one `cnt_step`. Changes of `ti1` alone give none. On that step, `cnt_up` = 1 when `ti1` equals the new `ti2`.
- R5: Mode 2: a change of `ti1` gives one `cnt_step`. Changes of `ti2` alone give none. On that step, `cnt_up` = 1 when the new `ti1` differs from `ti2`.
- R6: Mode 3: a change of exactly one of `ti1` or `ti2` gives one step, with direction as in R5 for `ti1` and R4 for `ti2`. If both change in the same cycle, no step is produced.
- R7: In modes 1 to 3, `cnt_up` keeps its previous value in every cycle without a step.
- R8: Mode 4 (reset): a rising edge of the trigger raises `cnt_clear` and `upd_req` together for one cycle. `cnt_step` follows `tick_en`.
- R9: Mode 5 (gated): `cnt_step` is `tick_en` AND the trigger level. When the trigger is low there is no step and no clear.
- R10: Mode 6 (trigger start): a rising edge of the trigger pulses `run_set` for one cycle. `cnt_step` follows `tick_en`, and a falling edge has no effect.
- R11: Mode 7 (external clock): `cnt_step` pulses once per rising edge of the trigger, whatever the value of `tick_en`.
- R12: Outside modes 1 to 3, `cnt_up` is 1. `cnt_clear` and `upd_req` appear only in mode 4, and `run_set` appears only in mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal count tick |
| ti1 | input | 1 | Filtered encoder / timer input 1 |
| ti2 | input | 1 | Filtered encoder / timer input 2 |
| trig_src | input | NUM_TRIG | Candidate trigger sources |
| mode_sel | input | 3 | Slave mode (0 free, 1-3 encoder, 4 reset, 5 gated, 6 start, 7 ext clock) |
| trig_sel | input | TSEL_W | Index of the selected trigger source |
| cnt_step | output | 1 | Counter advance strobe |
| cnt_up | output | 1 | Count direction, 1 = up |
| cnt_clear | output | 1 | Counter reinitialise request |
| upd_req | output | 1 | Register update event request |
| run_set | output | 1 | Request to set the counter run bit |

## Verification
The embedded properties check on every cycle the invariants that relate one cycle's inputs to the next cycle's outputs. These are: free-run stepping, gating, the pairing of clear with update, the mode restrictions on clear and run-set, and the holding of the encoder direction. Only the bench's sweeps show the exact edge-to-strobe mapping in each encoder variant. The sweeps also cover the direction value on each quadrature transition, the rejection of simultaneous changes, and the trigger selection across all sources.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;
  typedef enum logic [2:0] {
    SM_FREE   = 3'd0,
    SM_ENC_B  = 3'd1,
    SM_ENC_A  = 3'd2,
    SM_ENC_AB = 3'd3,
    SM_RESET  = 3'd4,
    SM_GATED  = 3'd5,
    SM_START  = 3'd6,
    SM_EXTCLK = 3'd7
  } slv_mode_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = sig[i] & ~prev_q[i];
    assign chg[i]  = sig[i] ^ prev_q[i];
  end
endmodule

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux #(
  parameter int NUM_TRIG = 8,
  localparam int TSEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic [NUM_TRIG-1:0] trig_src,
  input  logic [TSEL_W-1:0]   trig_sel,
  output logic                trgi
);
  always_comb begin
    trgi = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (int'(trig_sel) == i) trgi = trig_src[i];
    end
  end
endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec
  import tmr_slave_pkg::*;
(
  input  slv_mode_e mode,
  input  logic      ti1,
  input  logic      ti2,
  input  logic      chg1,
  input  logic      chg2,
  input  logic      up_q,
  output logic      step,
  output logic      up_nxt
);
  logic dir_a;
  logic dir_b;

  assign dir_a = ti1 ^ ti2;
  assign dir_b = ~(ti1 ^ ti2);

  always_comb begin
    step   = 1'b0;
    up_nxt = up_q;
    unique case (mode)
      SM_ENC_B: if (chg2) begin
        step   = 1'b1;
        up_nxt = dir_b;
      end
      SM_ENC_A: if (chg1) begin
        step   = 1'b1;
        up_nxt = dir_a;
      end
      SM_ENC_AB: if (chg1 ^ chg2) begin
        step   = 1'b1;
        up_nxt = chg1 ? dir_a : dir_b;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
  import tmr_slave_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  localparam int TSEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                ti1,
  input  logic                ti2,
  input  logic [NUM_TRIG-1:0] trig_src,
  input  logic [2:0]          mode_sel,
  input  logic [TSEL_W-1:0]   trig_sel,
  output logic                cnt_step,
  output logic                cnt_up,
  output logic                cnt_clear,
  output logic                upd_req,
  output logic                run_set
);
  localparam int N_EDGE = 3;

  slv_mode_e         mode;
  logic              trgi;
  logic [N_EDGE-1:0] rise;
  logic [N_EDGE-1:0] chg;
  logic              trg_rise;
  logic              qd_step;
  logic              qd_up;
  logic              step_d, up_d, clr_d, set_d;

  assign mode = slv_mode_e'(mode_sel);

  tmr_trig_mux #(.NUM_TRIG(NUM_TRIG)) u_mux (
    .trig_src (trig_src),
    .trig_sel (trig_sel),
    .trgi     (trgi)
  );

  tmr_edge_det #(.W(N_EDGE)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   ({trgi, ti2, ti1}),
    .rise  (rise),
    .chg   (chg)
  );

  assign trg_rise = rise[2];

  tmr_quad_dec u_quad (
    .mode   (mode),
    .ti1    (ti1),
    .ti2    (ti2),
    .chg1   (chg[0]),
    .chg2   (chg[1]),
    .up_q   (cnt_up),
    .step   (qd_step),
    .up_nxt (qd_up)
  );

  always_comb begin
    step_d = 1'b0;
    up_d   = 1'b1;
    clr_d  = 1'b0;
    set_d  = 1'b0;
    unique case (mode)
      SM_FREE:   step_d = tick_en;
      SM_ENC_B, SM_ENC_A, SM_ENC_AB: begin
        step_d = qd_step;
        up_d   = qd_up;
      end
      SM_RESET: begin
        step_d = tick_en;
        clr_d  = trg_rise;
      end
      SM_GATED:  step_d = tick_en & trgi;
      SM_START: begin
        step_d = tick_en;
        set_d  = trg_rise;
      end
      SM_EXTCLK: step_d = trg_rise;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_step  <= 1'b0;
      cnt_up    <= 1'b1;
      cnt_clear <= 1'b0;
      upd_req   <= 1'b0;
      run_set   <= 1'b0;
    end else begin
      cnt_step  <= step_d;
      cnt_up    <= up_d;
      cnt_clear <= clr_d;
      upd_req   <= clr_d;
      run_set   <= set_d;
    end
  end

  // Checker state: set after the first clock edge out of reset.
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R2
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode_sel) == 3'd0) |-> (cnt_step == $past(tick_en)));

  // R9
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode_sel) == 3'd5 && !$past(trgi)) |-> !cnt_step);

  // R8
  clear_upd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |-> upd_req);

  // R12
  clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && cnt_clear) |-> ($past(mode_sel) == 3'd4));

  // R12
  set_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && run_set) |-> ($past(mode_sel) == 3'd6));

  // R12
  dir_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && ($past(mode_sel) == 3'd0 || $past(mode_sel[2]))) |-> cnt_up);

  // R7
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode_sel) inside {3'd1, 3'd2, 3'd3} && !cnt_step)
      |-> $stable(cnt_up));

  // R11
  ext_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(mode_sel) == 3'd7 && cnt_step) |-> $past(trg_rise));
endmodule

// File: tb/tmr_slave_ctl_tb.sv
`timescale 1ns/1ps
module tmr_slave_ctl_tb;
  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en, ti1, ti2;
  logic [NT-1:0] trig_src;
  logic [2:0]    mode_sel;
  logic [2:0]    trig_sel;
  logic          cnt_step, cnt_up, cnt_clear, upd_req, run_set;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic m_p1, m_p2, m_pt, m_up;

  always #2.5 clk = ~clk;

  tmr_slave_ctl #(.NUM_TRIG(NT)) u_dut (
    .clk, .rst_n, .tick_en, .ti1, .ti2, .trig_src, .mode_sel, .trig_sel,
    .cnt_step, .cnt_up, .cnt_clear, .upd_req, .run_set
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  function automatic string step_tag(input int m);
    case (m)
      0: return "R2 free step";
      1: return "R4 enc1 step";
      2: return "R5 enc2 step";
      3: return "R6 enc3 step";
      4: return "R8 reset-mode step";
      5: return "R9 gated step";
      6: return "R10 start-mode step";
      default: return "R11 ext clock step";
    endcase
  endfunction

  // Drive at a negedge, expect after the next posedge, compare at the following negedge.
  task automatic apply(input int m, input int s, input logic tk,
                       input logic a, input logic b, input logic [NT-1:0] src);
    logic t, rz, c1, c2, e_step, e_up, e_clr, e_set;
    mode_sel = 3'(m); trig_sel = 3'(s); tick_en = tk; ti1 = a; ti2 = b; trig_src = src;
    t  = src[s];
    rz = t & ~m_pt;
    c1 = a ^ m_p1;
    c2 = b ^ m_p2;
    e_step = 1'b0; e_up = 1'b1; e_clr = 1'b0; e_set = 1'b0;
    case (m)
      0: e_step = tk;
      1: begin e_up = m_up; if (c2) begin e_step = 1'b1; e_up = (a == b); end end
      2: begin e_up = m_up; if (c1) begin e_step = 1'b1; e_up = (a != b); end end
      3: begin
        e_up = m_up;
        if (c1 && !c2) begin e_step = 1'b1; e_up = (a != b); end
        if (c2 && !c1) begin e_step = 1'b1; e_up = (a == b); end
      end
      4: begin e_step = tk; e_clr = rz; end
      5: e_step = tk & t;
      6: begin e_step = tk; e_set = rz; end
      default: e_step = rz;
    endcase
    m_p1 = a; m_p2 = b; m_pt = t; m_up = e_up;
    @(posedge clk);
    @(negedge clk);
    check(step_tag(m), cnt_step, e_step);
    check((m >= 1 && m <= 3) ? "R7 enc direction" : "R12 fixed up", cnt_up, e_up);
    check((m == 4) ? "R8 clear" : "R12 no clear", cnt_clear, e_clr);
    check((m == 4) ? "R8 update" : "R12 no update", upd_req, e_clr);
    check((m == 6) ? "R10 run set" : "R12 no run set", run_set, e_set);
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; ti1 = 1'b0; ti2 = 1'b0;
    trig_src = '0; mode_sel = 3'd0; trig_sel = 3'd0;
    m_p1 = 0; m_p2 = 0; m_pt = 0; m_up = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 step", cnt_step, 1'b0);
    check("R1 up", cnt_up, 1'b1);
    check("R1 clear", cnt_clear, 1'b0);
    check("R1 update", upd_req, 1'b0);
    check("R1 run set", run_set, 1'b0);
    tick_en = 1'b0;
    rst_n = 1'b1;

    // Near-exhaustive sweep: every mode, every trigger source, 32 input patterns.
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < NT; s++)
        for (int v = 0; v < 32; v++) begin
          logic [NT-1:0] src;
          src = {NT{v[4]}} ^ (NT'(v[3] ^ v[4]) << s);
          apply(m, s, v[0], v[1], v[2], src);
        end

    // R3: only the selected source matters (ext clock, source 5).
    apply(7, 5, 1'b0, 1'b0, 1'b0, 8'h00);
    apply(7, 5, 1'b0, 1'b0, 1'b0, 8'h04);
    check("R3 unselected source ignored", cnt_step, 1'b0);
    apply(7, 5, 1'b0, 1'b0, 1'b0, 8'h24);
    check("R3 selected source steps", cnt_step, 1'b1);

    // R6: forward then reverse quadrature cycle, then simultaneous change.
    apply(3, 0, 1'b0, 1'b0, 1'b0, 8'h00);
    apply(3, 0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R6 forward a-edge up", cnt_up, 1'b1);
    apply(3, 0, 1'b0, 1'b1, 1'b1, 8'h00);
    check("R6 forward b-edge up", cnt_up, 1'b1);
    apply(3, 0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R6 reverse b-edge down", cnt_up, 1'b0);
    apply(3, 0, 1'b0, 1'b0, 1'b1, 8'h00);
    check("R6 simultaneous change no step", cnt_step, 1'b0);
    check("R7 direction held", cnt_up, 1'b0);

    // R10: falling trigger edge has no effect.
    apply(6, 1, 1'b0, 1'b0, 1'b0, 8'h02);
    apply(6, 1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R10 falling edge ignored", run_set, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule